// File: doc/BRIEF.md
# Frame and Multiframe Sync Pulse Generator

This block makes two periodic marker pulses from a synthesized output clock. The frame pulse repeats once per frame, which is a programmed number of output clock cycles (nominally one 8 kHz period). The multiframe pulse repeats once every four frames (nominally 2 kHz). Both pulses are registered on the output clock, so their edges line up with its rising edges. Each output has its own active level and its own pulse length in clock cycles.

The frame phase can be made to follow an external sync signal. Up to three such signals can be connected, each running at 2, 4 or 8 kHz, and one of them is selected. With disciplining turned on, a rising edge on the selected signal starts a new frame at once. When the selected signal is declared as 2 kHz, the same edge also starts a new multiframe. The external signals are asynchronous to the output clock and pass through a two-stage synchronizer before edge detection.

Top module: `fsp_sync_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, both outputs take their inactive level on that edge. The inactive level is low when the matching `*_act_high` input is 1 and high when it is 0.
- R2: While `enable` is low, both outputs go inactive on the next edge and the frame and multiframe phases restart. On the first rising edge at which `enable` is sampled high again, both pulses become active.
- R3: With disciplining off, the frame pulse becomes active once every L clock cycles. L is `frame_len`, and a value below 2 counts as 2.
- R4: The multiframe pulse becomes active on the same edge as the frame pulse, on the first frame after reset or enable and on every fourth frame after that.
- R5: Each output stays active for W consecutive cycles, where W is its width input (`fs_width` or `mfs_width`). A width of 0 counts as 1, and a width of L or more counts as L-1.
- R6: An output whose `*_act_high` input is 1 pulses high from a low idle level. When that input is 0, the output is inverted: it idles high and pulses low.
- R7: With `disc_en` high, suppose a rising edge on the selected sync input is first sampled high at clock edge A. A new frame then starts, and its frame pulse becomes active at edge A+3. The next frame follows L cycles later unless another sync edge arrives first.
- R8: On a sync-forced frame start, `ref_rate` equal to 2 (2 kHz) also restarts the multiframe, so the multiframe pulse becomes active together with that frame pulse. For `ref_rate` values 0 (8 kHz), 1 (4 kHz) and 3, the multiframe count advances by one, as it does at a normal frame boundary.
- R9: Sync edges have no effect on the outputs when `disc_en` is low, or when `ref_sel` is 3 or more (no input selected).
- R10: Edges on sync inputs other than the one that `ref_sel` selects (index 0, 1 or 2) have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesized output clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the generator; low holds both outputs inactive |
| frame_len | input | 16 | Clock cycles per frame |
| fs_width | input | 16 | Frame pulse length in cycles |
| mfs_width | input | 16 | Multiframe pulse length in cycles |
| fs_act_high | input | 1 | Frame pulse active level (1 = high) |
| mfs_act_high | input | 1 | Multiframe pulse active level (1 = high) |
| disc_en | input | 1 | Lets the selected sync input re-phase the frames |
| ref_sel | input | 2 | Index of the sync input to follow |
| ref_rate | input | 2 | Rate of the selected sync input: 0 = 8 kHz, 1 = 4 kHz, 2 = 2 kHz |
| ref_sync | input | 3 | Asynchronous external sync inputs |
| fs_out | output | 1 | Frame sync pulse |
| mfs_out | output | 1 | Multiframe sync pulse |

## Verification
The hardest case to reach from the ports is a sync edge that lands at an arbitrary frame position, including inside a running pulse and while the multiframe count is partway through. The stimulus toggles a sync input on a period that is not a multiple of the frame length. Over a few hundred cycles this sweeps the forced restart across every frame position. A reference model predicts every output cycle through the synchronizer delay, so a restart that comes one cycle early or late, or a multiframe phase handled wrongly, shows up at the output.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  // Declared rate of the selected external sync input
  typedef enum logic [1:0] {
    RATE_8K   = 2'd0,
    RATE_4K   = 2'd1,
    RATE_2K   = 2'd2,
    RATE_RSVD = 2'd3
  } ref_rate_e;

  // Output channel indices
  localparam int unsigned N_OUT      = 2;
  localparam int unsigned OUT_FRAME  = 0;
  localparam int unsigned OUT_MFRAME = 1;

  // Shortest legal frame in clock cycles
  localparam int unsigned MIN_FRAME = 2;

endpackage

// File: rtl/fsp_ref_detect.sv
// Synchronizes the external sync inputs, selects one and flags its rising edge.
module fsp_ref_detect #(
  parameter int NUM_SYNC = 3,
  parameter int SEL_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SYNC-1:0] ref_sync,
  input  logic [SEL_W-1:0]    ref_sel,
  output logic                edge_p
);

  logic [NUM_SYNC-1:0] sync_s1;
  logic [NUM_SYNC-1:0] sync_s2;
  logic                picked;
  logic                picked_d;

  // Two-stage synchronizer per input
  for (genvar i = 0; i < NUM_SYNC; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) begin
        sync_s1[i] <= 1'b0;
        sync_s2[i] <= 1'b0;
      end else begin
        sync_s1[i] <= ref_sync[i];
        sync_s2[i] <= sync_s1[i];
      end
    end
  end

  // Selection after synchronization; out-of-range index selects nothing
  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < NUM_SYNC; i++) begin
      if (ref_sel == SEL_W'(i)) picked = sync_s2[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) picked_d <= 1'b0;
    else     picked_d <= picked;
  end

  assign edge_p = picked & ~picked_d;

endmodule

// File: rtl/fsp_frame_timer.sv
// Frame position counter and multiframe phase counter.
module fsp_frame_timer #(
  parameter int CNT_W    = 16,
  parameter int MF_RATIO = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] frame_len,   // already clamped to >= 2
  input  logic             resync,
  input  logic             mf_resync,
  output logic             frame_start,
  output logic             mframe_start
);

  localparam int MF_W = (MF_RATIO > 1) ? $clog2(MF_RATIO) : 1;

  logic [CNT_W-1:0] pos_q;
  logic [MF_W-1:0]  mf_q;
  logic [MF_W-1:0]  mf_next;
  logic             at_end;

  assign at_end  = (pos_q >= frame_len - 1'b1);
  assign mf_next = (mf_q == MF_W'(MF_RATIO - 1)) ? '0 : mf_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      pos_q <= '0;
      mf_q  <= '0;
    end else if (resync) begin
      pos_q <= '0;
      mf_q  <= mf_resync ? '0 : mf_next;
    end else if (at_end) begin
      pos_q <= '0;
      mf_q  <= mf_next;
    end else begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign frame_start  = enable && (pos_q == '0);
  assign mframe_start = frame_start && (mf_q == '0);

endmodule

// File: rtl/fsp_pulse_shaper.sv
// Stretches a one-cycle start into a registered pulse of programmed length and level.
module fsp_pulse_shaper #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             start,
  input  logic [CNT_W-1:0] width,     // already clamped to >= 1
  input  logic             act_high,
  output logic             pulse_out
);

  logic             act_q, act_n;
  logic [CNT_W-1:0] rem_q, rem_n;

  always_comb begin
    act_n = act_q;
    rem_n = rem_q;
    if (start) begin
      act_n = 1'b1;
      rem_n = width - 1'b1;
    end else if (act_q) begin
      if (rem_q == '0) act_n = 1'b0;
      else             rem_n = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      act_q     <= 1'b0;
      rem_q     <= '0;
      pulse_out <= ~act_high;
    end else begin
      act_q     <= act_n;
      rem_q     <= rem_n;
      pulse_out <= act_n ~^ act_high;
    end
  end

endmodule

// File: rtl/fsp_sync_gen.sv
// Frame / multiframe sync pulse generator top.
module fsp_sync_gen
  import fsp_pkg::*;
#(
  parameter int  CNT_W    = 16,
  parameter int  NUM_SYNC = 3,
  parameter int  MF_RATIO = 4,
  localparam int SEL_W    = (NUM_SYNC > 1) ? $clog2(NUM_SYNC) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [CNT_W-1:0]    frame_len,
  input  logic [CNT_W-1:0]    fs_width,
  input  logic [CNT_W-1:0]    mfs_width,
  input  logic                fs_act_high,
  input  logic                mfs_act_high,
  input  logic                disc_en,
  input  logic [SEL_W-1:0]    ref_sel,
  input  logic [1:0]          ref_rate,
  input  logic [NUM_SYNC-1:0] ref_sync,
  output logic                fs_out,
  output logic                mfs_out
);

  logic [CNT_W-1:0] eff_len;
  logic             ref_edge;
  logic             resync;
  logic             mf_resync;
  logic             frame_start, mframe_start;

  logic [N_OUT-1:0] start_v;
  logic [N_OUT-1:0] pol_v;
  logic [N_OUT-1:0] out_v;
  logic [CNT_W-1:0] req_w  [N_OUT];
  logic [CNT_W-1:0] wid_v  [N_OUT];

  function automatic logic [CNT_W-1:0] clamp_width(input logic [CNT_W-1:0] w,
                                                   input logic [CNT_W-1:0] len);
    logic [CNT_W-1:0] lim;
    lim = len - 1'b1;
    if (w == '0)      return CNT_W'(1);
    else if (w > lim) return lim;
    else              return w;
  endfunction

  assign eff_len = (frame_len < CNT_W'(MIN_FRAME)) ? CNT_W'(MIN_FRAME) : frame_len;

  fsp_ref_detect #(
    .NUM_SYNC (NUM_SYNC),
    .SEL_W    (SEL_W)
  ) u_ref (
    .clk      (clk),
    .rst      (rst),
    .ref_sync (ref_sync),
    .ref_sel  (ref_sel),
    .edge_p   (ref_edge)
  );

  assign resync    = disc_en & ref_edge;
  assign mf_resync = (ref_rate_e'(ref_rate) == RATE_2K);

  fsp_frame_timer #(
    .CNT_W    (CNT_W),
    .MF_RATIO (MF_RATIO)
  ) u_timer (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .frame_len    (eff_len),
    .resync       (resync),
    .mf_resync    (mf_resync),
    .frame_start  (frame_start),
    .mframe_start (mframe_start)
  );

  assign start_v[OUT_FRAME]  = frame_start;
  assign start_v[OUT_MFRAME] = mframe_start;
  assign pol_v[OUT_FRAME]    = fs_act_high;
  assign pol_v[OUT_MFRAME]   = mfs_act_high;
  assign req_w[OUT_FRAME]    = fs_width;
  assign req_w[OUT_MFRAME]   = mfs_width;

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    assign wid_v[g] = clamp_width(req_w[g], eff_len);

    fsp_pulse_shaper #(
      .CNT_W (CNT_W)
    ) u_shaper (
      .clk       (clk),
      .rst       (rst),
      .enable    (enable),
      .start     (start_v[g]),
      .width     (wid_v[g]),
      .act_high  (pol_v[g]),
      .pulse_out (out_v[g])
    );
  end

  assign fs_out  = out_v[OUT_FRAME];
  assign mfs_out = out_v[OUT_MFRAME];

endmodule

// File: rtl/fsp_sync_gen_chk.sv
// Property checker bound to the sync pulse generator.
module fsp_sync_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic [CNT_W-1:0] frame_len,
  input logic [CNT_W-1:0] fs_width,
  input logic             fs_act_high,
  input logic             mfs_act_high,
  input logic             disc_en,
  input logic             fs_out,
  input logic             mfs_out
);

  logic             fs_a, mfs_a, fs_prev;
  logic             fs_rise, fs_fall;
  logic [CNT_W:0]   gap, hi_cnt;
  logic             clean, had_rise;
  logic [CNT_W-1:0] len_prev, wid_prev;
  logic             pol_prev;
  logic             quiet;
  logic [CNT_W-1:0] exp_len, exp_wid;

  assign fs_a    = (fs_out == fs_act_high);
  assign mfs_a   = (mfs_out == mfs_act_high);
  assign fs_rise = fs_a & ~fs_prev;
  assign fs_fall = ~fs_a & fs_prev;

  assign exp_len = (frame_len < CNT_W'(2)) ? CNT_W'(2) : frame_len;
  assign exp_wid = (fs_width == '0) ? CNT_W'(1) :
                   (fs_width >= exp_len) ? exp_len - 1'b1 : fs_width;

  assign quiet = enable && !disc_en && (frame_len == len_prev) &&
                 (fs_width == wid_prev) && (fs_act_high == pol_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_prev  <= 1'b0;
      gap      <= '0;
      hi_cnt   <= '0;
      clean    <= 1'b0;
      had_rise <= 1'b0;
      len_prev <= frame_len;
      wid_prev <= fs_width;
      pol_prev <= fs_act_high;
    end else begin
      fs_prev  <= fs_a;
      len_prev <= frame_len;
      wid_prev <= fs_width;
      pol_prev <= fs_act_high;
      had_rise <= had_rise | fs_rise;
      if (fs_rise)            gap <= (CNT_W+1)'(1);
      else if (~&gap)         gap <= gap + 1'b1;
      if (fs_rise)            hi_cnt <= (CNT_W+1)'(1);
      else if (fs_a && ~&hi_cnt) hi_cnt <= hi_cnt + 1'b1;
      clean <= fs_rise ? 1'b1 : (clean & quiet);
    end
  end

  AST_FS_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (fs_out == !$past(fs_act_high)));  // R2

  AST_MFS_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (mfs_out == !$past(mfs_act_high)));  // R2

  AST_MF_INSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
    ($stable(fs_act_high) && $stable(mfs_act_high) && $rose(mfs_a)) |-> fs_a);  // R4

  AST_FS_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (fs_rise && had_rise && clean && quiet) |-> (gap == {1'b0, exp_len}));  // R3

  AST_FS_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (fs_fall && had_rise && clean && quiet) |-> (hi_cnt == {1'b0, exp_wid}));  // R5

endmodule

bind fsp_sync_gen fsp_sync_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .enable       (enable),
  .frame_len    (frame_len),
  .fs_width     (fs_width),
  .fs_act_high  (fs_act_high),
  .mfs_act_high (mfs_act_high),
  .disc_en      (disc_en),
  .fs_out       (fs_out),
  .mfs_out      (mfs_out)
);

// File: tb/fsp_sync_gen_tb.sv
`timescale 1ns/1ps
module fsp_sync_gen_tb;

  localparam int CW  = 16;
  localparam int NS  = 3;
  localparam int SW  = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          enable;
  logic [CW-1:0] frame_len, fs_width, mfs_width;
  logic          fs_act_high, mfs_act_high, disc_en;
  logic [SW-1:0] ref_sel;
  logic [1:0]    ref_rate;
  logic [NS-1:0] ref_sync;
  logic          fs_out, mfs_out;

  typedef struct {
    logic  fs;
    logic  mfs;
    string tag;
  } exp_t;

  exp_t   sb_q[$];
  string  cur_tag = "R1";
  int     n_checks = 0;
  int     n_fail   = 0;
  int     cyc      = 0;
  bit     done     = 0;

  // sync toggler controls
  logic [NS-1:0] tog_mask = '0;
  int            tog_half = 0;

  // reference model state
  logic [NS-1:0] m_s1 = '0, m_s2 = '0;
  logic          m_s3 = 1'b0;
  int            m_pos = 0, m_mf = 0, m_fl = 0, m_ml = 0;
  logic          m_fa = 0, m_ma = 0;

  always #4 clk = ~clk;

  fsp_sync_gen u_dut (
    .clk (clk), .rst (rst), .enable (enable),
    .frame_len (frame_len), .fs_width (fs_width), .mfs_width (mfs_width),
    .fs_act_high (fs_act_high), .mfs_act_high (mfs_act_high),
    .disc_en (disc_en), .ref_sel (ref_sel), .ref_rate (ref_rate),
    .ref_sync (ref_sync), .fs_out (fs_out), .mfs_out (mfs_out)
  );

  function automatic int lim_w(input int w, input int len);
    if (w == 0) return 1;
    if (w > len - 1) return len - 1;
    return w;
  endfunction

  // Driver side: predicts outputs after each edge and queues them
  always @(posedge clk) begin
    logic sel_hi, edge_now, st, mst;
    int   len, wf, wm;
    exp_t e;
    sel_hi   = (int'(ref_sel) < NS) ? m_s2[ref_sel] : 1'b0;
    edge_now = sel_hi & ~m_s3;
    m_s3 = rst ? 1'b0 : sel_hi;
    m_s2 = rst ? '0 : m_s1;
    m_s1 = rst ? '0 : ref_sync;
    len = (int'(frame_len) < 2) ? 2 : int'(frame_len);
    wf  = lim_w(int'(fs_width), len);
    wm  = lim_w(int'(mfs_width), len);
    if (rst || !enable) begin
      m_pos = 0; m_mf = 0; m_fl = 0; m_ml = 0; m_fa = 0; m_ma = 0;
    end else begin
      st  = (m_pos == 0);
      mst = st && (m_mf == 0);
      if (st)  m_fl = wf;
      if (mst) m_ml = wm;
      m_fa = (m_fl > 0); if (m_fl > 0) m_fl--;
      m_ma = (m_ml > 0); if (m_ml > 0) m_ml--;
      if (disc_en && edge_now) begin
        m_pos = 0;
        m_mf  = (ref_rate == 2'd2) ? 0 : (m_mf + 1) % 4;
      end else if (m_pos >= len - 1) begin
        m_pos = 0;
        m_mf  = (m_mf + 1) % 4;
      end else begin
        m_pos++;
      end
    end
    e.fs  = m_fa ? fs_act_high  : ~fs_act_high;
    e.mfs = m_ma ? mfs_act_high : ~mfs_act_high;
    e.tag = cur_tag;
    sb_q.push_back(e);
  end

  // Monitor side: compares away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      n_checks++;
      if (fs_out !== e.fs || mfs_out !== e.mfs) begin
        n_fail++;
        $display("FAIL %s cycle %0d: fs/mfs actual %b%b expected %b%b",
                 e.tag, cyc, fs_out, mfs_out, e.fs, e.mfs);
      end
    end
  end

  // External sync stimulus
  initial begin
    int tc;
    tc = 0;
    forever begin
      @(negedge clk);
      if (tog_half != 0) begin
        tc++;
        if (tc >= tog_half) begin
          tc = 0;
          ref_sync = ref_sync ^ tog_mask;
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic run(input int n, input string tag);
    cur_tag = tag;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; enable = 1'b1; frame_len = 16'd10; fs_width = 16'd3; mfs_width = 16'd5;
    fs_act_high = 1'b1; mfs_act_high = 1'b1; disc_en = 1'b0;
    ref_sel = 2'd0; ref_rate = 2'd0; ref_sync = '0;
    run(5, "R1");
    @(negedge clk); rst = 1'b0;
    run(120, "R3");
    run(120, "R4");
    fs_width = 16'd0; mfs_width = 16'd40;            // R5 clamps both ways
    run(60, "R5");
    frame_len = 16'd1; fs_width = 16'd5;             // R3/R5 minimum frame
    run(20, "R5");
    frame_len = 16'd12; fs_width = 16'd3; mfs_width = 16'd6;
    fs_act_high = 1'b0; mfs_act_high = 1'b0;
    run(80, "R6");
    fs_act_high = 1'b1; mfs_act_high = 1'b1;
    enable = 1'b0;
    run(8, "R2");
    enable = 1'b1;
    run(60, "R2");
    frame_len = 16'd20; disc_en = 1'b1; ref_sel = 2'd1; ref_rate = 2'd0;
    tog_mask = 3'b010; tog_half = 17;
    run(300, "R7");
    ref_rate = 2'd2;
    run(300, "R8");
    ref_rate = 2'd1;
    run(200, "R8");
    disc_en = 1'b0;
    run(200, "R9");
    disc_en = 1'b1; ref_sel = 2'd3;
    run(200, "R9");
    ref_sel = 2'd1; tog_mask = 3'b101; ref_rate = 2'd2;
    run(200, "R10");
    ref_sel = 2'd2; tog_mask = 3'b100; ref_rate = 2'd0; tog_half = 23;
    run(200, "R7");
    tog_half = 0;
    rst = 1'b1;
    run(5, "R1");
    rst = 1'b0;
    run(40, "R3");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule